// File: doc/BRIEF.md
# Amplifier Control Register Slave on a Two-Wire Serial Bus

This block is a target-only device on a two-wire serial bus, the usual clock-plus-open-drain-data scheme, at Standard-mode and Fast-mode bit rates. It holds three 8-bit control registers for a stereo speaker amplifier and decodes them into gain, automatic-gain-control and power-state fields for the analog section. Bus lines are sampled by a system clock many times faster than the bus clock. Both lines pass through two synchronising flops. A START is a falling data edge while the bus clock is high. A STOP is a rising data edge while the bus clock is high.

A write frame carries the device address with the direction bit at 0, then a register index, then one or more data bytes. The index moves up by one after every data byte. A read frame sends no index. Data always comes out from register 0, then register 1, then register 2, and this continues for as long as the controller acknowledges. Bits that the register layout does not use always hold zero. Clock stretching, multi-controller arbitration and High-speed mode are not supported.

Top module: `amp_ctl_i2c_slave`

## Requirements
- R1: The 7-bit device address is 0x5B. The address byte 0xB6 (direction bit 0) selects a write and 0xB7 (direction bit 1) selects a read, and both are acknowledged. Any other address byte gets no acknowledge, and the block ignores the bus from then until the next START.
- R2: In a write frame, the byte after the address is the register index and every byte after that is stored in the indexed register. The block pulls data low during each acknowledge slot.
- R3: After each data byte of a write, the register index increases by one, so several bytes written in one frame go to consecutive registers.
- R4: A read frame begins at register 0 and returns register 0, then 1, then 2, then register 0 again, for as long as the controller acknowledges. A not-acknowledge from the controller ends the transfer, and the data line stays released.
- R5: Register 0 bits 6, 5, 4 and 0 and all of register 2 always read as zero, whatever was written to them.
- R6: After reset, all three registers hold 0x00 and the data line is released.
- R7: Register 0 decodes as follows. gain_hi = bit 7 (1 selects the higher gain). agc_on = bit 3. save_on = NOT bit 2. standby_on = NOT bit 1.
- R8: Register 1 decodes as follows. attack_sel = bits 1:0, recovery_sel = bits 4:2, onlevel_sel = bits 7:5.
- R9: A data byte written to a register index above 2 is acknowledged and then discarded. No register changes.
- R10: The block changes its data pull-down only while the synchronised bus clock is low. It releases the data line after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as received |
| sda_in | input | 1 | Bus data line as received |
| sda_pull | output | 1 | 1 pulls the data line low (open-drain driver enable) |
| gain_hi | output | 1 | Higher amplifier gain selected |
| agc_on | output | 1 | Automatic gain control enabled |
| save_on | output | 1 | Speaker power-save active |
| standby_on | output | 1 | Amplifier and charge pump in standby |
| attack_sel | output | 2 | AGC attack-time selection |
| recovery_sel | output | 3 | AGC recovery-time selection |
| onlevel_sel | output | 3 | AGC threshold-level selection |

## Verification
If the bit counter or the frame state is wrong, the failure shows up within a byte of the fault: an acknowledge is missing or lands in the wrong slot, or a read byte comes back shifted by one position. An error in the index or read-pointer update does not show on the lines. It shows at the decoded outputs after the following STOP, or as a wrong byte order when registers are read back. For that reason every write is followed by a full read-back. A wrong reserved-bit mask shows as non-zero bits in that same read-back.

// File: rtl/amp_ctl_pkg.sv
package amp_ctl_pkg;
  localparam int unsigned NREG      = 3;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned PTR_W     = $clog2(NREG);
  localparam logic [6:0]  DEV_ADDR  = 7'h5B;

  localparam int unsigned B_GAIN    = 7;
  localparam int unsigned B_AGC     = 3;
  localparam int unsigned B_SAVE_N  = 2;
  localparam int unsigned B_STBY_N  = 1;
  localparam int unsigned ATK_LSB   = 0;
  localparam int unsigned ATK_W     = 2;
  localparam int unsigned REC_LSB   = 2;
  localparam int unsigned REC_W     = 3;
  localparam int unsigned LVL_LSB   = 5;
  localparam int unsigned LVL_W     = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_ADDR, ST_SUB, ST_ACK_SUB,
    ST_WDATA, ST_ACK_WDATA, ST_RDATA, ST_RACK, ST_SKIP
  } fsm_t;

  // Bits kept by each register; everything else stores as zero
  function automatic logic [BYTE_W-1:0] keep_mask(input int unsigned idx);
    case (idx)
      0:       keep_mask = 8'h8E;
      1:       keep_mask = 8'hFF;
      default: keep_mask = 8'h00;
    endcase
  endfunction

  // Write index advances by one and sticks at the top value
  function automatic logic [BYTE_W-1:0] idx_step(input logic [BYTE_W-1:0] cur);
    idx_step = (cur == {BYTE_W{1'b1}}) ? cur : cur + 1'b1;
  endfunction

  // Read pointer cycles 0..NREG-1
  function automatic logic [PTR_W-1:0] rptr_step(input logic [PTR_W-1:0] cur);
    rptr_step = (cur == PTR_W'(NREG - 1)) ? '0 : cur + 1'b1;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES:0] scl_pipe;
  logic [STAGES:0] sda_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-1:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-1:0], sda_in};
    end
  end

  logic scl_prev, sda_prev;
  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_prev = scl_pipe[STAGES];
  assign sda_prev = sda_pipe[STAGES];

  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_evt = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_evt  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_frame_engine.sv
module i2c_frame_engine
  import amp_ctl_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sda_s,
  input  logic                    scl_rise,
  input  logic                    scl_fall,
  input  logic                    start_evt,
  input  logic                    stop_evt,
  input  logic [NREG*BYTE_W-1:0]  reg_flat,
  output logic                    sda_oe,
  output logic                    wr_stb,
  output logic [BYTE_W-1:0]       wr_idx,
  output logic [BYTE_W-1:0]       wr_data,
  output logic                    addr_miss
);
  fsm_t              st;
  logic [BYTE_W-1:0] sh;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sub;
  logic [BYTE_W-1:0] tx;
  logic [PTR_W-1:0]  rptr;
  logic              rw;
  logic              nack;
  logic              byte_full;

  function automatic logic [BYTE_W-1:0] byte_at(input logic [NREG*BYTE_W-1:0] v,
                                                input logic [PTR_W-1:0] p);
    byte_at = v[p*BYTE_W +: BYTE_W];
  endfunction

  assign byte_full = (cnt == 4'd8);

  logic [BYTE_W-1:0] first_byte, next_byte;
  assign first_byte = byte_at(reg_flat, '0);
  assign next_byte  = byte_at(reg_flat, rptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sh        <= '0;
      cnt       <= '0;
      sub       <= '0;
      tx        <= '0;
      rptr      <= '0;
      rw        <= 1'b0;
      nack      <= 1'b0;
      sda_oe    <= 1'b0;
      wr_stb    <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
      addr_miss <= 1'b0;
    end else begin
      wr_stb    <= 1'b0;
      addr_miss <= 1'b0;
      if (stop_evt) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_evt) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (scl_rise && !byte_full) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && byte_full) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  st     <= ST_ACK_ADDR;
                end else begin
                  addr_miss <= 1'b1;
                  st        <= ST_SKIP;
                end
              end else if (st == ST_SUB) begin
                sub    <= sh;
                sda_oe <= 1'b1;
                st     <= ST_ACK_SUB;
              end else begin
                wr_stb  <= 1'b1;
                wr_idx  <= sub;
                wr_data <= sh;
                sub     <= idx_step(sub);
                sda_oe  <= 1'b1;
                st      <= ST_ACK_WDATA;
              end
            end
          end
          ST_ACK_ADDR: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                tx     <= first_byte;
                sda_oe <= ~first_byte[BYTE_W-1];
                rptr   <= rptr_step('0);
                st     <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_SUB;
              end
            end
          end
          ST_ACK_SUB, ST_ACK_WDATA: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
                st     <= ST_RACK;
              end else begin
                cnt    <= cnt + 4'd1;
                tx     <= {tx[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nack <= sda_s;
            end else if (scl_fall) begin
              if (nack) begin
                st <= ST_SKIP;
              end else begin
                tx     <= next_byte;
                sda_oe <= ~next_byte[BYTE_W-1];
                rptr   <= rptr_step(rptr);
                st     <= ST_RDATA;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/amp_ctl_regs.sv
module amp_ctl_regs
  import amp_ctl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_stb,
  input  logic [BYTE_W-1:0]      wr_idx,
  input  logic [BYTE_W-1:0]      wr_data,
  output logic [NREG*BYTE_W-1:0] reg_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [BYTE_W-1:0] KEEP = keep_mask(g);
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (wr_stb && wr_idx == BYTE_W'(g))
        q <= wr_data & KEEP;
    end
    assign reg_flat[g*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/amp_ctl_i2c_slave.sv
module amp_ctl_i2c_slave
  import amp_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  output logic       gain_hi,
  output logic       agc_on,
  output logic       save_on,
  output logic       standby_on,
  output logic [1:0] attack_sel,
  output logic [2:0] recovery_sel,
  output logic [2:0] onlevel_sel
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic wr_stb, addr_miss;
  logic [BYTE_W-1:0] wr_idx, wr_data;
  logic [NREG*BYTE_W-1:0] reg_flat;
  logic [BYTE_W-1:0] r0, r1;

  i2c_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .reg_flat(reg_flat), .sda_oe(sda_pull), .wr_stb(wr_stb),
    .wr_idx(wr_idx), .wr_data(wr_data), .addr_miss(addr_miss)
  );

  amp_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_data(wr_data), .reg_flat(reg_flat)
  );

  assign r0 = reg_flat[0 +: BYTE_W];
  assign r1 = reg_flat[BYTE_W +: BYTE_W];

  assign gain_hi      = r0[B_GAIN];
  assign agc_on       = r0[B_AGC];
  assign save_on      = ~r0[B_SAVE_N];
  assign standby_on   = ~r0[B_STBY_N];
  assign attack_sel   = r1[ATK_LSB +: ATK_W];
  assign recovery_sel = r1[REC_LSB +: REC_W];
  assign onlevel_sel  = r1[LVL_LSB +: LVL_W];
endmodule

// File: rtl/amp_ctl_i2c_checker.sv
module amp_ctl_i2c_checker
  import amp_ctl_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sda_pull,
  input logic                   scl_s,
  input logic                   start_evt,
  input logic                   stop_evt,
  input logic                   addr_miss,
  input logic                   wr_stb,
  input logic [BYTE_W-1:0]      wr_idx,
  input logic [NREG*BYTE_W-1:0] reg_flat
);
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull) else $error("stop did not release data"); // R10

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull) && !$past(start_evt) && !$past(stop_evt)) |-> !scl_s)
    else $error("pull changed with clock high"); // R10

  AST_FOREIGN_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> !sda_pull) else $error("foreign address acknowledged"); // R1

  AST_HIGH_IDX_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_idx > 8'd2) |=> $stable(reg_flat))
    else $error("write above index 2 changed a register"); // R9

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_flat[7:0] & 8'h71) == 8'h00) && (reg_flat[23:16] == 8'h00))
    else $error("reserved bits non-zero"); // R5
endmodule

bind amp_ctl_i2c_slave amp_ctl_i2c_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull), .scl_s(scl_s),
  .start_evt(start_evt), .stop_evt(stop_evt), .addr_miss(addr_miss),
  .wr_stb(wr_stb), .wr_idx(wr_idx), .reg_flat(reg_flat)
);

// File: tb/tb_amp_ctl_i2c_slave.sv
`timescale 1ns/1ps
module tb_amp_ctl_i2c_slave;
  localparam int Q = 8;  // clock cycles per quarter bit

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull, gain_hi, agc_on, save_on, standby_on;
  logic [1:0] attack_sel;
  logic [2:0] recovery_sel, onlevel_sel;
  wire sda_line = sda_m & ~sda_pull;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [7:0] model [3];

  always #2 clk = ~clk;

  amp_ctl_i2c_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .gain_hi(gain_hi), .agc_on(agc_on),
    .save_on(save_on), .standby_on(standby_on), .attack_sel(attack_sel),
    .recovery_sel(recovery_sel), .onlevel_sel(onlevel_sel)
  );

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Register 0 keeps bits 7,3,2,1; register 1 keeps all; register 2 keeps none
  function automatic logic [7:0] stored(input int idx, input logic [7:0] d);
    logic [7:0] r;
    r = '0;
    if (idx == 0) begin
      r[7] = d[7]; r[3] = d[3]; r[2] = d[2]; r[1] = d[1];
    end else if (idx == 1) r = d;
    return r;
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    acked = ~sda_line;
    wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl_m = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl_m = 1'b0;
    end
    wq(Q); sda_m = give_ack ? 1'b0 : 1'b1; wq(Q);
    scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q); sda_m = 1'b1;
  endtask

  task automatic write_frame(input logic [7:0] sub, input int n, input logic [7:0] d [4]);
    bit a;
    logic [7:0] s;
    bus_start();
    send_byte(8'hB6, a); chk(a, "R1 write address ack", a, 1);
    send_byte(sub, a);   chk(a, "R2 index ack", a, 1);
    s = sub;
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], a);
      chk(a, (s > 2) ? "R9 high index ack" : "R2 data ack", a, 1);
      if (s < 3) model[s] = stored(s, d[k]);
      if (s != 8'hFF) s = s + 1;  // R3 index advances
    end
    bus_stop();
    chk(sda_pull == 1'b0, "R10 released after stop", sda_pull, 0);
  endtask

  task automatic read_check(input int n, input string req);
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hB7, a); chk(a, "R1 read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk(b == model[k % 3], req, b, model[k % 3]);
    end
    chk(sda_pull == 1'b0, "R4 released after nack", sda_pull, 0);
    bus_stop();
  endtask

  task automatic field_check();
    chk(gain_hi == model[0][7], "R7 gain_hi", gain_hi, model[0][7]);
    chk(agc_on == model[0][3], "R7 agc_on", agc_on, model[0][3]);
    chk(save_on == ~model[0][2], "R7 save_on", save_on, ~model[0][2]);
    chk(standby_on == ~model[0][1], "R7 standby_on", standby_on, ~model[0][1]);
    chk(attack_sel == model[1][1:0], "R8 attack_sel", attack_sel, model[1][1:0]);
    chk(recovery_sel == model[1][4:2], "R8 recovery_sel", recovery_sel, model[1][4:2]);
    chk(onlevel_sel == model[1][7:5], "R8 onlevel_sel", onlevel_sel, model[1][7:5]);
  endtask

  initial begin
    logic [7:0] d [4];
    bit a;
    void'($urandom(32'h5EED_1234));
    model[0] = 0; model[1] = 0; model[2] = 0;
    wq(5); rst_n = 1'b1; wq(5);

    // R6 reset state
    chk(sda_pull == 1'b0, "R6 line released", sda_pull, 0);
    chk(standby_on && save_on && !gain_hi && !agc_on, "R6 reset fields",
        {standby_on, save_on, gain_hi, agc_on}, 4'b1100);
    field_check();
    read_check(3, "R6 reset registers");

    // R5: all ones into register 0 keeps only the used bits
    d = '{8'hFF, 8'h00, 8'h00, 8'h00};
    write_frame(8'h00, 1, d);
    field_check();
    read_check(3, "R5 reserved bits");

    // R3: three bytes from index 0
    d = '{8'h0A, 8'hA7, 8'h55, 8'h00};
    write_frame(8'h00, 3, d);
    field_check();
    read_check(3, "R3 auto-increment");

    // R1: foreign address, later bytes ignored
    bus_start();
    send_byte(8'hB4, a); chk(!a, "R1 foreign address nack", a, 0);
    send_byte(8'h00, a); chk(!a, "R1 ignored index", a, 0);
    send_byte(8'hFF, a); chk(!a, "R1 ignored data", a, 0);
    bus_stop();
    field_check();
    read_check(3, "R1 registers unchanged");

    // R9: index above 2
    d = '{8'h12, 8'h34, 8'h00, 8'h00};
    write_frame(8'h03, 2, d);
    read_check(3, "R9 discard above 2");

    // R3/R5: index 1 then 2
    d = '{8'h3C, 8'hFF, 8'h00, 8'h00};
    write_frame(8'h01, 2, d);
    field_check();
    read_check(3, "R5 register 2 zero");

    // R4: read wraps past register 2
    read_check(5, "R4 read wrap");

    // R4: repeated START from write into read
    bus_start();
    send_byte(8'hB6, a); send_byte(8'h01, a); send_byte(8'hC3, a);
    model[1] = 8'hC3;
    chk(a, "R2 data before restart", a, 1);
    read_check(2, "R4 read after repeated start");
    field_check();

    // random frames
    for (int it = 0; it < 20; it++) begin
      int unsigned sub = $urandom_range(0, 4);
      int unsigned n = $urandom_range(1, 3);
      for (int k = 0; k < 4; k++) d[k] = 8'($urandom);
      write_frame(8'(sub), n, d);
      field_check();
      read_check(3, "R2 random write read-back");
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule